// File: doc/BRIEF.md
# Gradient Link Word Framer

The framer sits between the gradient word FIFOs and a 48-bit parallel link that moves one word per word-clock cycle. The FIFO side works with a gradient word made of an address, a data value and three flags: last-in-package, data-valid and next-gradient. All three flags are active high on that side. On the link the same flags are active low, and the most significant bit carries even parity over the rest of the word.

On the transmit path the block accepts one FIFO entry per clock through a valid/ready handshake. It packs the entry and computes parity, then drives the word from a register on the next clock. In every slot with no accepted entry it drives a fixed idle word with all three flags inactive. On the receive path it samples a line word each clock and recomputes parity. Words with bad parity, and words that claim data and a next-gradient marker at once, are dropped and raise sticky error bits. Idle words are discarded. Every other word is unpacked into a one-entry output register that drains through a valid/ready handshake.

Top module: `grad_link_framer`

## Requirements
- R1: Transmitted line layout (bits numbered 1 to 48, vector index = bit - 1): address in bits 47..38, data in bits 37..18, last flag in bit 5, data-valid in bit 4, next-gradient in bit 3, each flag inverted (0 = active). Bits 17..6 and bits 2..1 are sent as 0.
- R2: Bit 48 of every transmitted word makes the count of ones over bits 1..48 even.
- R3: In the cycle after any clock edge with no accepted transmit entry, the line output is the idle word 48'h8000_0000_001C: flag bits all 1, parity 1, everything else 0. The line output also holds this value during reset.
- R4: tx_ready_o is high from the first clock after reset. An entry accepted at a clock edge appears on line_tx_o right after that edge (one clock of latency), so one entry is taken per clock.
- R5: A received word with good parity and at least one active flag that is not rejected by R7 appears on the receive outputs one clock after it is sampled. Its address, data and flags are decoded using the R1 positions, with the flags inverted to active high.
- R6: A received word whose bits 1..48 hold an odd number of ones is not forwarded and sets parity_err_o. parity_err_o stays set until err_clr_i.
- R7: A received word with good parity that has data-valid and next-gradient both active is not forwarded and sets proto_err_o, which is sticky until err_clr_i. A forwarded word never shows both flags.
- R8: A received word with good parity and no active flag (an idle word) is not forwarded. Received bits 17..6 and 2..1 do not affect the forwarded fields.
- R9: While rx_valid_o is high and rx_ready_i is low, the receive outputs hold steady. A word that would be forwarded in that state is dropped and sets overrun_err_o, which is sticky until err_clr_i.
- R10: err_clr_i high at a clock edge clears all three error bits. A new error event at the same edge takes priority, so that bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit entry present |
| tx_ready_o | output | 1 | Transmit entry accepted this cycle |
| tx_addr_i | input | 10 | Transmit address |
| tx_data_i | input | 20 | Transmit data |
| tx_last_i | input | 1 | Last word of package, active high |
| tx_dv_i | input | 1 | Data-valid, active high |
| tx_ng_i | input | 1 | Next-gradient, active high |
| line_tx_o | output | 48 | Outgoing line word |
| line_rx_i | input | 48 | Incoming line word |
| rx_valid_o | output | 1 | Received entry present |
| rx_ready_i | input | 1 | Consumer takes the received entry |
| rx_addr_o | output | 10 | Received address |
| rx_data_o | output | 20 | Received data |
| rx_last_o | output | 1 | Received last flag, active high |
| rx_dv_o | output | 1 | Received data-valid, active high |
| rx_ng_o | output | 1 | Received next-gradient, active high |
| err_clr_i | input | 1 | Clear sticky error bits |
| parity_err_o | output | 1 | Sticky parity error |
| proto_err_o | output | 1 | Sticky flag-combination error |
| overrun_err_o | output | 1 | Sticky receive overrun |

## Verification
The bench sweeps all eight flag combinations against several address and data patterns in both directions, with noise placed in the reserved bits and a parity flip on every receive pattern. A design with a field off by one bit, flags left uninverted, or parity computed over the wrong span would fail the packed-word compare. A design that forwards the data-plus-next-gradient combination, forwards idle words, or lets reserved noise leak into the fields would show a valid output where none is expected. The bench also checks that the sticky bits stay set across idle cycles and that a new error beats a clear at the same edge. It stalls the consumer to check that a second word overwriting the held entry is caught as an overrun.

// File: rtl/glf_pkg.sv
package glf_pkg;
  localparam int LINE_W    = 48;
  localparam int ADDR_W    = 10;
  localparam int DATA_W    = 20;
  localparam int PAR_IX    = LINE_W - 1;
  localparam int ADDR_LSB  = PAR_IX - ADDR_W;
  localparam int DATA_LSB  = ADDR_LSB - DATA_W;
  localparam int NLAST_IX  = 4;
  localparam int NDV_IX    = 3;
  localparam int NNG_IX    = 2;
  localparam int N_ERR     = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              last;
    logic              dv;
    logic              ng;
  } grad_word_t;

  localparam logic [LINE_W-1:0] IDLE_WORD =
    (LINE_W'(1) << PAR_IX) | (LINE_W'(1) << NLAST_IX) |
    (LINE_W'(1) << NDV_IX) | (LINE_W'(1) << NNG_IX);

  function automatic logic [LINE_W-1:0] pack_word(grad_word_t w);
    logic [LINE_W-1:0] l;
    l = '0;
    l[ADDR_LSB +: ADDR_W] = w.addr;
    l[DATA_LSB +: DATA_W] = w.data;
    l[NLAST_IX]           = ~w.last;
    l[NDV_IX]             = ~w.dv;
    l[NNG_IX]             = ~w.ng;
    l[PAR_IX]             = ^l[PAR_IX-1:0];
    return l;
  endfunction

  function automatic grad_word_t unpack_word(logic [LINE_W-1:0] l);
    grad_word_t w;
    w.addr = l[ADDR_LSB +: ADDR_W];
    w.data = l[DATA_LSB +: DATA_W];
    w.last = ~l[NLAST_IX];
    w.dv   = ~l[NDV_IX];
    w.ng   = ~l[NNG_IX];
    return w;
  endfunction
endpackage

// File: rtl/glf_tx_packer.sv
module glf_tx_packer
  import glf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  grad_word_t        word_i,
  output logic [LINE_W-1:0] line_o
);
  logic              ready_q;
  logic [LINE_W-1:0] line_q;
  logic              accept;

  assign accept = valid_i & ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      line_q  <= IDLE_WORD;
    end else begin
      ready_q <= 1'b1;
      line_q  <= accept ? pack_word(word_i) : IDLE_WORD;
    end
  end

  assign ready_o = ready_q;
  assign line_o  = line_q;

  p_tx_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^line_o) == 1'b0);
  p_tx_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_o) |=> line_o == IDLE_WORD);
  p_tx_resv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o[DATA_LSB-1:NLAST_IX+1] == '0 && line_o[NNG_IX-1:0] == '0);
  p_tx_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> line_o[DATA_LSB +: DATA_W] == $past(word_i.data));
endmodule

// File: rtl/glf_rx_unpacker.sv
module glf_rx_unpacker
  import glf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  output logic              valid_o,
  input  logic              ready_i,
  output grad_word_t        word_o,
  output logic [N_ERR-1:0]  err_ev_o
);
  grad_word_t dec;
  logic       par_ok, both, any, fwd, free;
  logic       valid_q;
  grad_word_t word_q;

  assign dec    = unpack_word(line_i);
  assign par_ok = ~(^line_i);
  assign both   = dec.dv & dec.ng;
  assign any    = dec.last | dec.dv | dec.ng;
  assign fwd    = par_ok & ~both & any;
  assign free   = ~valid_q | ready_i;

  // event order: parity, flag combination, overrun
  assign err_ev_o = {fwd & ~free, par_ok & both, ~par_ok};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (fwd && free) begin
      valid_q <= 1'b1;
      word_q  <= dec;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;

  p_rx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(word_o));
  p_rx_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(word_o.dv && word_o.ng));
  p_rx_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (word_o.last || word_o.dv || word_o.ng));
  p_rx_badpar_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((^line_i) && ready_i) |=> !valid_o);
endmodule

// File: rtl/glf_sticky.sv
module glf_sticky
  import glf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ERR-1:0] ev_i,
  input  logic             clr_i,
  output logic [N_ERR-1:0] err_o
);
  for (genvar g = 0; g < N_ERR; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= 1'b0;
      else if (ev_i[g]) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
    end
    assign err_o[g] = q;

    p_sticky_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o[g] && !clr_i) |=> err_o[g]);
    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[g] |=> err_o[g]);
  end
endmodule

// File: rtl/grad_link_framer.sv
module grad_link_framer
  import glf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [ADDR_W-1:0] tx_addr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_last_i,
  input  logic              tx_dv_i,
  input  logic              tx_ng_i,
  output logic [LINE_W-1:0] line_tx_o,
  input  logic [LINE_W-1:0] line_rx_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_last_o,
  output logic              rx_dv_o,
  output logic              rx_ng_o,
  input  logic              err_clr_i,
  output logic              parity_err_o,
  output logic              proto_err_o,
  output logic              overrun_err_o
);
  grad_word_t       tx_word, rx_word;
  logic [N_ERR-1:0] err_ev, err_q;

  assign tx_word = '{addr: tx_addr_i, data: tx_data_i, last: tx_last_i,
                     dv: tx_dv_i, ng: tx_ng_i};

  glf_tx_packer i_tx (
    .clk_i, .rst_ni,
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .word_i  (tx_word),
    .line_o  (line_tx_o)
  );

  glf_rx_unpacker i_rx (
    .clk_i, .rst_ni,
    .line_i   (line_rx_i),
    .valid_o  (rx_valid_o),
    .ready_i  (rx_ready_i),
    .word_o   (rx_word),
    .err_ev_o (err_ev)
  );

  glf_sticky i_err (
    .clk_i, .rst_ni,
    .ev_i  (err_ev),
    .clr_i (err_clr_i),
    .err_o (err_q)
  );

  assign rx_addr_o     = rx_word.addr;
  assign rx_data_o     = rx_word.data;
  assign rx_last_o     = rx_word.last;
  assign rx_dv_o       = rx_word.dv;
  assign rx_ng_o       = rx_word.ng;
  assign parity_err_o  = err_q[0];
  assign proto_err_o   = err_q[1];
  assign overrun_err_o = err_q[2];
endmodule

// File: tb/test_grad_link_framer.sv
module test_grad_link_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [9:0]  tx_addr = '0;
  logic [19:0] tx_data = '0;
  logic        tx_last = 1'b0, tx_dv = 1'b0, tx_ng = 1'b0;
  logic [47:0] line_tx;
  logic [47:0] line_rx = 48'h8000_0000_001C;
  logic        rx_valid, rx_ready = 1'b1;
  logic [9:0]  rx_addr;
  logic [19:0] rx_data;
  logic        rx_last, rx_dv, rx_ng;
  logic        err_clr = 1'b0;
  logic        perr, proto, ovr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  localparam logic [47:0] IDLE = 48'h8000_0000_001C;

  always #10 clk = ~clk;

  grad_link_framer i_grad_link_framer (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_addr_i(tx_addr), .tx_data_i(tx_data),
    .tx_last_i(tx_last), .tx_dv_i(tx_dv), .tx_ng_i(tx_ng),
    .line_tx_o(line_tx), .line_rx_i(line_rx),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_addr_o(rx_addr), .rx_data_o(rx_data),
    .rx_last_o(rx_last), .rx_dv_o(rx_dv), .rx_ng_o(rx_ng),
    .err_clr_i(err_clr), .parity_err_o(perr),
    .proto_err_o(proto), .overrun_err_o(ovr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] build(input logic [9:0] a, input logic [19:0] d,
      input logic l, input logic v, input logic n, input logic [11:0] res,
      input logic [1:0] low, input bit flip);
    logic [47:0] e;
    int ones = 0;
    e = (48'(a) << 37) | (48'(d) << 17) | (48'(res) << 5) |
        (48'({~l, ~v, ~n}) << 2) | 48'(low);
    for (int i = 0; i < 47; i++) ones += int'(e[i]);
    e[47] = ((ones % 2) == 1) ^ flip;
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0]  a;
    logic [19:0] d;
    repeat (3) @(negedge clk);
    chk("R3 reset idle", 64'(line_tx), 64'(IDLE));
    chk("R5 reset rx_valid", 64'(rx_valid), 0);
    chk("R6 reset errors", 64'({perr, proto, ovr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 ready after reset", 64'(tx_ready), 1);
    chk("R3 idle after reset", 64'(line_tx), 64'(IDLE));

    // transmit sweep: R1 R2 R4 R3
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 4; k++) begin
        a = 10'((f * 37 + k * 301) % 1024);
        d = 20'((f * 40503 + k * 262147 + 5) % 1048576);
        tx_valid = 1'b1; tx_addr = a; tx_data = d;
        {tx_last, tx_dv, tx_ng} = 3'(f);
        @(negedge clk);
        chk("R1 R2 R4 tx word", 64'(line_tx),
            64'(build(a, d, f[2], f[1], f[0], 12'h0, 2'b0, 1'b0)));
        tx_valid = 1'b0;
        @(negedge clk);
        chk("R3 idle slot", 64'(line_tx), 64'(IDLE));
      end
    end
    // back-to-back acceptance, R4
    tx_valid = 1'b1; tx_addr = 10'h3FF; tx_data = 20'hFFFFF; {tx_last, tx_dv, tx_ng} = 3'b110;
    @(negedge clk);
    chk("R4 b2b first", 64'(line_tx), 64'(build(10'h3FF, 20'hFFFFF, 1, 1, 0, 0, 0, 0)));
    tx_addr = 10'h001; tx_data = 20'h00001; {tx_last, tx_dv, tx_ng} = 3'b001;
    @(negedge clk);
    chk("R4 b2b second", 64'(line_tx), 64'(build(10'h001, 20'h00001, 0, 0, 1, 0, 0, 0)));
    tx_valid = 1'b0;
    @(negedge clk);
    chk("R3 idle after burst", 64'(line_tx), 64'(IDLE));

    // receive sweep: R5 R6 R7 R8 R10
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 2; p++) begin
          bit fwd, e_par, e_pro;
          a = 10'((f * 91 + k * 203 + 7) % 1024);
          d = 20'((f * 77773 + k * 123457 + p * 999) % 1048576);
          e_par = (p == 1);
          e_pro = !e_par && f[1] && f[0];
          fwd   = !e_par && !e_pro && (f != 0);
          line_rx = build(a, d, f[2], f[1], f[0], 12'((k * 1365) % 4096), 2'(k), p == 1);
          @(negedge clk);
          chk("R5 R8 rx_valid", 64'(rx_valid), 64'(fwd));
          if (fwd) chk("R5 rx fields", 64'({rx_addr, rx_data, rx_last, rx_dv, rx_ng}),
                       64'({a, d, f[2], f[1], f[0]}));
          chk("R6 parity err", 64'(perr), 64'(e_par));
          chk("R7 proto err", 64'(proto), 64'(e_pro));
          line_rx = IDLE; err_clr = 1'b1;
          @(negedge clk);
          err_clr = 1'b0;
          chk("R10 cleared", 64'({perr, proto, ovr}), 0);
          chk("R8 idle not forwarded", 64'(rx_valid), 0);
        end
      end
    end

    // sticky hold, R6
    line_rx = build(10'h5, 20'h5, 0, 1, 0, 0, 0, 1);
    @(negedge clk);
    line_rx = IDLE;
    repeat (3) @(negedge clk);
    chk("R6 sticky hold", 64'(perr), 1);
    // set beats clear, R10
    line_rx = build(10'h5, 20'h5, 0, 0, 1, 0, 0, 1); err_clr = 1'b1;
    @(negedge clk);
    line_rx = IDLE; err_clr = 1'b0;
    chk("R10 set wins", 64'(perr), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R10 clear", 64'(perr), 0);

    // backpressure and overrun, R9
    rx_ready = 1'b0;
    line_rx = build(10'h2AA, 20'h12345, 1, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 first held", 64'({rx_valid, rx_addr, rx_data}), 64'({1'b1, 10'h2AA, 20'h12345}));
    line_rx = build(10'h155, 20'h54321, 0, 0, 1, 0, 0, 0);
    @(negedge clk);
    line_rx = IDLE;
    chk("R9 not overwritten", 64'({rx_valid, rx_addr, rx_data, rx_last, rx_dv, rx_ng}),
        64'({1'b1, 10'h2AA, 20'h12345, 3'b110}));
    chk("R9 overrun set", 64'(ovr), 1);
    @(negedge clk);
    chk("R9 stall hold", 64'({rx_valid, rx_addr}), 64'({1'b1, 10'h2AA}));
    rx_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", 64'(rx_valid), 0);
    chk("R9 overrun sticky", 64'(ovr), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule